// File: doc/BRIEF.md
# Frame Capture and Lane Serializer

This block sits behind a four-lane parallel FFT engine. On each valid input beat the engine presents four complex samples, one per lane. The block merges them into one AXI4-Stream of 64-bit words, one sample per word. Frame alignment comes from a start-of-frame marker on the input. No beat is buffered until that marker has been seen. After the marker, exactly one frame's worth of beats is taken in. Each output frame therefore holds a fixed number of samples, and TLAST marks the final word of each frame.

A small FIFO per lane absorbs the rate difference between four samples per beat and one word per cycle. Downstream TREADY backpressure is honoured. If the lane FIFOs fill, the block does not stall. It sets a sticky overflow flag, throws away everything it holds, and waits for the next frame start.

Top module: `fft_lane_serializer`

## Requirements
- R1: After a synchronous reset, `m_tvalid`, `m_tlast` and `ovf_flag` are 0.
- R2: While the capture stage is waiting, a beat with `s_valid`=1 and `s_sof`=0 is discarded and produces no output word. A beat with `s_valid`=1 and `s_sof`=1 becomes the first beat of a frame.
- R3: A beat can be accepted while the last lane's FIFO already holds FIFO_DEPTH beats. In that case the beat is discarded, all buffered words are discarded, and `m_tvalid` is 0 on the next cycle. `ovf_flag` becomes 1 and stays 1 until reset. Capture then waits for a new `s_sof`.
- R4: The four samples of a beat are emitted in lane order: lane 0 first, then 1, 2 and 3. Beats are emitted in the order they arrived.
- R5: Each output word carries the real part of a sample (signed 32 bits) in bits 31:0 and the imaginary part (signed 32 bits) in bits 63:32. Lane k of the input occupies bits k*32+31:k*32 of `s_re` and `s_im`.
- R6: `m_tlast` is 1 on every FRAME_LEN-th transferred word (512 by default) and on no other word.
- R7: After FRAME_LEN/4 beats the capture stage returns to waiting, and further beats without `s_sof` are discarded. An `s_sof` that arrives inside a frame is treated as ordinary data.
- R8: While `m_tvalid`=1 and `m_tready`=0, and no overflow occurs, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R9: With empty FIFOs, lane 0 of an accepted beat appears with `m_tvalid`=1 in the cycle right after the accepting edge. With `m_tready`=1 and one beat every four cycles, words then leave one per cycle.
- R10: A reset in the middle of a frame discards all buffered data, and the block again waits for `s_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input beat valid |
| s_sof | input | 1 | Beat is the first of a frame |
| s_re | input | 128 | Real parts, lane k in bits k*32+31:k*32 |
| s_im | input | 128 | Imaginary parts, same lane layout |
| m_tdata | output | 64 | Packed sample {imag, real} |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Sink ready |
| m_tlast | output | 1 | Last word of a frame |
| ovf_flag | output | 1 | Sticky FIFO overflow indication |

## Verification
Errors inside the block show up at the ports within a few cycles:
- A wrong lane pointer shows up within one word as swapped samples in `m_tdata`.
- A wrong output frame counter moves `m_tlast` off the 512th word, which is visible at the first frame end.
- A wrong beat counter in the capture stage shows up after the frame. Beats that should be dropped appear on the output, or expected ones are missing.
- A FIFO occupancy error either raises `ovf_flag` too early or lets data be lost silently. The per-cycle reference model catches both on the cycle they happen.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam int SAMP_W = 32;
    localparam int WORD_W = 2 * SAMP_W;

    // imag in the upper half, real in the lower half
    typedef struct packed {
        logic signed [SAMP_W-1:0] im;
        logic signed [SAMP_W-1:0] re;
    } cplx_t;

    typedef enum logic {
        CAP_WAIT = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_t;

    function automatic logic [WORD_W-1:0] pack_word(input cplx_t s);
        return {s.im, s.re};
    endfunction

endpackage

// File: rtl/sfx_lane_fifo.sv
module sfx_lane_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_pop;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign do_pop = pop && !empty;
    assign dout   = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({push && !full, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sfx_capture.sv
module sfx_capture
    import sfx_pkg::*;
#(
    parameter int BEATS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic any_full,
    output logic push,
    output logic flush,
    output logic ovf_flag
);
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    cap_state_t    state;
    logic [BW-1:0] beat_cnt;
    logic          accept;

    assign accept = in_valid && ((state == CAP_RUN) || in_sof);
    assign flush  = accept && any_full;
    assign push   = accept && !any_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAP_WAIT;
            beat_cnt <= '0;
            ovf_flag <= 1'b0;
        end else if (flush) begin
            ovf_flag <= 1'b1;
            state    <= CAP_WAIT;
            beat_cnt <= '0;
        end else if (push) begin
            if (state == CAP_WAIT) begin
                state    <= CAP_RUN;
                beat_cnt <= BW'(1);
            end else if (beat_cnt == BW'(BEATS - 1)) begin
                state    <= CAP_WAIT;
                beat_cnt <= '0;
            end else begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfx_out_seq.sv
module sfx_out_seq #(
    parameter int LANES     = 4,
    parameter int FRAME_LEN = 512,
    localparam int SEL_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [LANES-1:0] lane_empty,
    input  logic             m_tready,
    output logic             m_tvalid,
    output logic             m_tlast,
    output logic [SEL_W-1:0] lane_sel,
    output logic [LANES-1:0] pop
);
    localparam int CW = $clog2(FRAME_LEN);

    logic [CW-1:0] word_cnt;
    logic          xfer;

    assign m_tvalid = !lane_empty[lane_sel];
    assign m_tlast  = m_tvalid && (word_cnt == CW'(FRAME_LEN - 1));
    assign xfer     = m_tvalid && m_tready && !flush;

    for (genvar k = 0; k < LANES; k++) begin : g_pop
        assign pop[k] = xfer && (lane_sel == SEL_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lane_sel <= '0;
            word_cnt <= '0;
        end else if (xfer) begin
            lane_sel <= (lane_sel == SEL_W'(LANES - 1)) ? '0 : lane_sel + 1'b1;
            word_cnt <= (word_cnt == CW'(FRAME_LEN - 1)) ? '0 : word_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fft_lane_serializer.sv
module fft_lane_serializer
    import sfx_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FRAME_LEN  = 512,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s_valid,
    input  logic                      s_sof,
    input  logic [LANES*SAMP_W-1:0]   s_re,
    input  logic [LANES*SAMP_W-1:0]   s_im,
    output logic [WORD_W-1:0]         m_tdata,
    output logic                      m_tvalid,
    input  logic                      m_tready,
    output logic                      m_tlast,
    output logic                      ovf_flag
);
    localparam int BEATS = FRAME_LEN / LANES;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic              push, flush;
    logic [LANES-1:0]  lane_empty, lane_full, lane_pop;
    logic [SEL_W-1:0]  lane_sel;
    logic [WORD_W-1:0] head [LANES];

    sfx_capture #(.BEATS(BEATS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_valid),
        .in_sof   (s_sof),
        .any_full (|lane_full),
        .push     (push),
        .flush    (flush),
        .ovf_flag (ovf_flag)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        cplx_t smp;
        assign smp.re = s_re[k*SAMP_W +: SAMP_W];
        assign smp.im = s_im[k*SAMP_W +: SAMP_W];

        sfx_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .push  (push),
            .din   (pack_word(smp)),
            .pop   (lane_pop[k]),
            .dout  (head[k]),
            .empty (lane_empty[k]),
            .full  (lane_full[k])
        );
    end

    sfx_out_seq #(.LANES(LANES), .FRAME_LEN(FRAME_LEN)) u_out (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .lane_empty (lane_empty),
        .m_tready   (m_tready),
        .m_tvalid   (m_tvalid),
        .m_tlast    (m_tlast),
        .lane_sel   (lane_sel),
        .pop        (lane_pop)
    );

    assign m_tdata = head[lane_sel];

endmodule

// File: rtl/sfx_checks.sv
module sfx_checks #(
    parameter int FRAME_LEN = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        s_valid,
    input logic        s_sof,
    input logic [63:0] m_tdata,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        m_tlast,
    input logic        ovf_flag,
    input logic        flush
);
    localparam int CW = $clog2(FRAME_LEN);

    logic [CW-1:0] seen_words;
    logic          sof_seen;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            seen_words <= '0;
        end else if (m_tvalid && m_tready) begin
            seen_words <= (seen_words == CW'(FRAME_LEN - 1)) ? '0 : seen_words + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sof_seen <= 1'b0;
        end else if (s_valid && s_sof) begin
            sof_seen <= 1'b1;
        end
    end

    assert_no_data_before_sof_R2: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> sof_seen);

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_overflow_empties_R3: assert property (@(posedge clk) disable iff (rst)
        flush |=> !m_tvalid);

    assert_tlast_position_R6: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tlast == (seen_words == CW'(FRAME_LEN - 1))));

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready && !flush) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

bind fft_lane_serializer sfx_checks #(.FRAME_LEN(FRAME_LEN)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_sof    (s_sof),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .ovf_flag (ovf_flag),
    .flush    (flush)
);

// File: tb/fft_lane_serializer_bench.sv
module fft_lane_serializer_bench;

    localparam int LANES = 4;
    localparam int FLEN  = 512;
    localparam int DEPTH = 4;
    localparam int NBEAT = FLEN / LANES;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         s_valid = 1'b0;
    logic         s_sof = 1'b0;
    logic [127:0] s_re = '0;
    logic [127:0] s_im = '0;
    logic [63:0]  m_tdata;
    logic         m_tvalid;
    logic         m_tready = 1'b1;
    logic         m_tlast;
    logic         ovf_flag;

    always #10 clk = ~clk;

    fft_lane_serializer u_fft_lane_serializer (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_sof(s_sof),
        .s_re(s_re), .s_im(s_im), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .ovf_flag(ovf_flag)
    );

    int n_chk = 0;
    int n_err = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int words_out = 0;
    int tlast_out = 0;

    // reference model state
    logic [63:0] q[$];
    int m_ocnt = 0;
    int m_run = 0;
    int m_bcnt = 0;
    bit m_ovf = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_re(input int tag, input int lane);
        return 32'(tag * 4 + lane - 1000);
    endfunction

    function automatic logic [31:0] mk_im(input int tag, input int lane);
        return 32'(32'h7000_0000 ^ (tag * 131 + lane * 7));
    endfunction

    task automatic model_step(input bit v, input bit sof, input bit rdy, input bit r);
        int w;
        bit full, acc, hs;
        if (r) begin
            q.delete(); m_ocnt = 0; m_run = 0; m_bcnt = 0; m_ovf = 0;
            return;
        end
        w = q.size();
        full = ((w + 3) / 4) >= DEPTH;
        acc = v && (m_run == 1 || sof);
        hs = (w > 0) && rdy;
        if (acc && full) begin
            m_ovf = 1; q.delete(); m_ocnt = 0; m_run = 0; m_bcnt = 0;
        end else begin
            if (hs) begin
                void'(q.pop_front());
                m_ocnt = (m_ocnt == FLEN - 1) ? 0 : m_ocnt + 1;
            end
            if (acc) begin
                for (int k = 0; k < LANES; k++)
                    q.push_back({s_im[k*32 +: 32], s_re[k*32 +: 32]});
                if (m_run == 0) begin
                    m_run = 1; m_bcnt = 1;
                end else if (m_bcnt == NBEAT - 1) begin
                    m_run = 0; m_bcnt = 0;
                end else begin
                    m_bcnt++;
                end
            end
        end
    endtask

    task automatic tick();
        logic [63:0] pre_data;
        bit hold;
        case (rdy_mode)
            0: m_tready = 1'b1;
            1: m_tready = (cyc % 3) != 2;
            default: m_tready = 1'b0;
        endcase
        pre_data = m_tdata;
        hold = m_tvalid && !m_tready;
        if (m_tvalid && m_tready && !rst) begin
            words_out++;
            if (m_tlast) tlast_out++;
        end
        @(posedge clk);
        cyc++;
        begin
            bit ovf_before;
            ovf_before = m_ovf;
            model_step(s_valid, s_sof, m_tready, rst);
            if (m_ovf && !ovf_before) hold = 0;
            if (rst) hold = 0;
        end
        @(negedge clk);
        check(m_tvalid == (q.size() > 0), "R9 tvalid", 64'(m_tvalid), 64'(q.size() > 0));
        if (m_tvalid && q.size() > 0) begin
            check(m_tdata == q[0], "R4/R5 tdata", m_tdata, q[0]);
            check(m_tlast == (m_ocnt == FLEN - 1), "R6 tlast", 64'(m_tlast), 64'(m_ocnt == FLEN - 1));
        end
        check(ovf_flag == m_ovf, "R3 ovf_flag", 64'(ovf_flag), 64'(m_ovf));
        if (hold) check(m_tdata == pre_data && m_tvalid, "R8 hold", m_tdata, pre_data);
    endtask

    task automatic send_beat(input bit sof, input int tag, input int gap);
        s_valid = 1'b1;
        s_sof = sof;
        for (int k = 0; k < LANES; k++) begin
            s_re[k*32 +: 32] = mk_re(tag, k);
            s_im[k*32 +: 32] = mk_im(tag, k);
        end
        tick();
        s_valid = 1'b0;
        s_sof = 1'b0;
        repeat (gap) tick();
    endtask

    task automatic send_frame(input int base, input int gap, input int mid_sof);
        for (int b = 0; b < NBEAT; b++)
            send_beat(b == 0 || b == mid_sof, base + b, gap);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int base_w;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        check(!m_tvalid && !m_tlast && !ovf_flag, "R1 reset outputs", {61'd0, m_tvalid, m_tlast, ovf_flag}, 64'd0);

        // R2: beats before any frame start are dropped
        for (int i = 0; i < 5; i++) send_beat(1'b0, 900 + i, 3);
        check(!m_tvalid && words_out == 0, "R2 pre-sof beats dropped", 64'(words_out), 64'd0);

        // R9/R5: first beat appears next cycle, packed {im, re}
        send_beat(1'b1, 0, 0);
        check(m_tvalid == 1'b1, "R9 latency one cycle", 64'(m_tvalid), 64'd1);
        check(m_tdata == {mk_im(0, 0), mk_re(0, 0)}, "R5 packing lane0", m_tdata, {mk_im(0, 0), mk_re(0, 0)});
        repeat (3) tick();
        for (int b = 1; b < NBEAT; b++) send_beat(b == 60, b, 3);   // R7: mid-frame sof is data
        repeat (20) tick();
        check(words_out == FLEN, "R7 one frame of words", 64'(words_out), 64'(FLEN));
        check(tlast_out == 1, "R6 single tlast per frame", 64'(tlast_out), 64'd1);

        // R7: beats after frame end without sof are dropped
        for (int i = 0; i < 3; i++) send_beat(1'b0, 950 + i, 3);
        repeat (10) tick();
        check(words_out == FLEN, "R7 post-frame beats dropped", 64'(words_out), 64'(FLEN));

        // backpressure frame
        rdy_mode = 1;
        send_frame(2000, 7, -1);
        rdy_mode = 0;
        repeat (30) tick();
        check(words_out == 2 * FLEN && tlast_out == 2, "R6 second frame", 64'(words_out), 64'(2 * FLEN));
        check(!ovf_flag, "R8 no overflow under backpressure", 64'(ovf_flag), 64'd0);

        // R8: stall holds output
        rdy_mode = 2;
        send_beat(1'b1, 3000, 0);
        begin
            logic [63:0] held;
            held = m_tdata;
            repeat (3) tick();
            check(m_tvalid && m_tdata == held, "R8 stalled word steady", m_tdata, held);
        end

        // R3: fill FIFOs, then overflow
        for (int i = 1; i < DEPTH; i++) send_beat(1'b0, 3000 + i, 0);
        check(!ovf_flag, "R3 full but not yet overflowed", 64'(ovf_flag), 64'd0);
        send_beat(1'b0, 3100, 0);
        check(ovf_flag && !m_tvalid, "R3 overflow flushes", {62'd0, ovf_flag, m_tvalid}, 64'd2);
        rdy_mode = 0;
        base_w = words_out;
        for (int i = 0; i < 3; i++) send_beat(1'b0, 3200 + i, 3);
        repeat (10) tick();
        check(words_out == base_w, "R3 waits for sof after overflow", 64'(words_out), 64'(base_w));
        send_frame(4000, 3, -1);
        repeat (20) tick();
        check(words_out == base_w + FLEN, "R3 realigned frame", 64'(words_out), 64'(base_w + FLEN));
        check(ovf_flag, "R3 flag sticky", 64'(ovf_flag), 64'd1);

        // R10: reset mid-frame
        for (int b = 0; b < 10; b++) send_beat(b == 0, 5000 + b, 3);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check(!m_tvalid && !ovf_flag, "R10 reset clears", {62'd0, m_tvalid, ovf_flag}, 64'd0);
        base_w = words_out;
        for (int i = 0; i < 4; i++) send_beat(1'b0, 5100 + i, 3);
        check(words_out == base_w && !m_tvalid, "R10 waits for sof", 64'(words_out), 64'(base_w));
        send_frame(6000, 3, -1);
        repeat (20) tick();
        check(words_out == base_w + FLEN, "R10 frame after reset", 64'(words_out), 64'(base_w + FLEN));

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule